// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Controller

This block is the target side of a byte-wide serial EEPROM with an SPI mode 0 link. A host lowers the chip select, shifts in an 8-bit command most significant bit first, then any address and data bytes, and raises the chip select to end the frame. The block decodes the command, keeps a write-enable latch and a small configuration register, and serves sequential reads and page writes to a byte array held in flops.

All link pins are brought into the system clock domain through two-flop synchronizers. Edges of the serial clock and the select are detected on the system clock, so the serial clock must run several times slower than the system clock. Writes land in a page buffer and are copied into the array by an internal write cycle of a fixed number of system clocks. While that cycle runs the block reports busy and refuses all other work.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset the array holds 0x00 in every byte, the write-enable latch is clear, and a status read returns 0x00. With the select high, SO is high-impedance.
- R2: Command bytes are decoded with bit 3 ignored: 0x06 sets the latch, 0x04 clears it, 0x05 reads status, 0x01 writes status, 0x03 reads the array, 0x02 writes the array. A byte whose upper four bits are not all zero is ignored.
- R3: Status bit 1 reads 1 while the write-enable latch is set. Clearing the latch works whatever the level of WP_n.
- R4: An array write or status write that is not preceded by a latch-set command is ignored: no busy indication and the array is unchanged.
- R5: An array write takes a 16-bit address, MSB first, followed by data bytes. They fill a 32-byte page buffer whose column wraps inside the page. The internal write starts only if the select rises after a whole number of data bytes (at least one). A frame that ends mid-byte stores nothing and leaves the latch set.
- R6: An array read takes a 16-bit address and then returns successive bytes while the select stays low. The address counts up across pages and wraps at the end of the array. Address bits above the array size are ignored.
- R7: While an internal write runs, a status read returns 0xFF in every byte. When the write ends after WR_CYCLES system clocks, status bit 0 reads 0 and the write-enable latch is clear.
- R8: While an internal write runs, every command other than a status read is ignored. In particular an array read leaves SO high-impedance.
- R9: A status write changes only bit 7 (write-pin protect enable), bit 3 and bit 2 (protect selection). It takes effect through an internal write cycle. Bits 6 to 4 read as 0 when idle.
- R10: Protect selection {bit3,bit2} = 01 guards the upper quarter of the array, 10 the upper half, and 11 all of it. A write whose start address falls in a guarded area is dropped without starting a cycle, and the latch stays set.
- R11: When status bit 7 is 1 and WP_n is low, a status write is ignored. With WP_n high it is accepted.
- R12: SI is sampled on rising SCK and SO changes after falling SCK. The first output bit is driven after the falling edge that follows the last command or address bit. SO is driven only during read-out and is high-impedance otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples the link and times the internal write |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Active-low chip select; a falling edge starts a frame |
| sck | input | 1 | Serial clock, mode 0 (idles low) |
| si | input | 1 | Serial data from host |
| wp_n | input | 1 | Active-low write-protect pin guarding the status write |
| so | output | 1 | Serial data to host, high-impedance when not shifting out |

## Verification
The array path is exercised with a multi-byte write that starts two bytes before a page end, so that read-back tells in-page wrap apart from linear increment. Reads that cross the top of the array check the address wrap and the discarded high address bits. A frame cut off after four bits separates the byte-boundary rule from a plain select-rise trigger. Each protect selection is tried with one write just inside and one just outside the guarded area, which tells the quarter, half and full decodes apart. Status writes are tried with WP_n both low and high. Opcodes with bit 3 set, and a non-zero upper nibble, confirm which bits the decoder uses. Status and array reads issued in the middle of an internal write show the all-ones status and the refused command.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

  // low three bits of a command byte (bit 3 ignored, upper nibble zero)
  localparam logic [2:0] CMD_STAT_WR = 3'b001;
  localparam logic [2:0] CMD_ARR_WR  = 3'b010;
  localparam logic [2:0] CMD_ARR_RD  = 3'b011;
  localparam logic [2:0] CMD_LOCK    = 3'b100;
  localparam logic [2:0] CMD_STAT_RD = 3'b101;
  localparam logic [2:0] CMD_UNLOCK  = 3'b110;

  typedef enum logic [2:0] {
    LS_IDLE,
    LS_CMD,
    LS_ADDR,
    LS_RDATA,
    LS_WDATA,
    LS_CFGW,
    LS_STAT,
    LS_SKIP
  } link_state_e;

endpackage

// File: rtl/eeprom_pin_sync.sv
module eeprom_pin_sync #(
  parameter int           W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_lvl
);

  logic [W-1:0] meta_q;
  logic [W-1:0] lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      lvl_q  <= RST_VAL;
    end else begin
      meta_q <= pin_in;
      lvl_q  <= meta_q;
    end
  end

  assign pin_lvl = lvl_q;

endmodule

// File: rtl/eeprom_link.sv
module eeprom_link
  import eeprom_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int PAGE_W = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cs_n_s,
  input  logic                     sck_s,
  input  logic                     si_s,
  input  logic                     wp_n_s,
  input  logic                     busy,
  input  logic                     wr_done,
  input  logic                     cfg_wpen,
  input  logic [1:0]               cfg_bp,
  input  logic [7:0]               rd_data,
  output logic [ADDR_W-1:0]        rd_addr,
  output logic                     pb_clr,
  output logic                     pb_we,
  output logic [PAGE_W-1:0]        pb_col,
  output logic [7:0]               pb_din,
  output logic [ADDR_W-PAGE_W-1:0] page_sel,
  output logic                     start_arr,
  output logic                     start_cfg,
  output logic [2:0]               cfg_din,
  output logic                     so_q,
  output logic                     so_oe
);

  link_state_e state, state_d;
  logic        cs_prev, sck_prev;
  logic [2:0]  bitcnt, bitcnt_d;
  logic [6:0]  sh, sh_d;
  logic [15:0] addr, addr_d;
  logic        addr_hi, addr_hi_d;
  logic        is_wr, is_wr_d;
  logic        wel, wel_d;
  logic [7:0]  tx, tx_d;
  logic [2:0]  outcnt, outcnt_d;
  logic        so_q_d, so_oe_d;
  logic        got, got_d;
  logic        prot, prot_d;
  logic [2:0]  cfg_buf, cfg_buf_d;

  logic        cs_active, cs_fall, cs_rise, sck_rise, sck_fall;
  logic [7:0]  byte_in, stat_word, load;

  assign cs_active = ~cs_prev;
  assign cs_fall   = cs_prev & ~cs_n_s;
  assign cs_rise   = ~cs_prev & cs_n_s;
  assign sck_rise  = ~sck_prev & sck_s;
  assign sck_fall  = sck_prev & ~sck_s;
  assign byte_in   = {sh, si_s};
  assign stat_word = busy ? 8'hFF : {cfg_wpen, 3'b000, cfg_bp, wel, 1'b0};

  function automatic logic guarded(input logic [1:0] bp, input logic [1:0] top);
    case (bp)
      2'b01:   guarded = &top;
      2'b10:   guarded = top[1];
      2'b11:   guarded = 1'b1;
      default: guarded = 1'b0;
    endcase
  endfunction

  always_comb begin
    state_d   = state;
    bitcnt_d  = bitcnt;
    sh_d      = sh;
    addr_d    = addr;
    addr_hi_d = addr_hi;
    is_wr_d   = is_wr;
    wel_d     = wel;
    tx_d      = tx;
    outcnt_d  = outcnt;
    so_q_d    = so_q;
    so_oe_d   = so_oe;
    got_d     = got;
    prot_d    = prot;
    cfg_buf_d = cfg_buf;
    pb_clr    = 1'b0;
    pb_we     = 1'b0;
    start_arr = 1'b0;
    start_cfg = 1'b0;
    load      = 8'h00;

    if (cs_fall) begin
      state_d   = LS_CMD;
      bitcnt_d  = 3'd0;
      addr_hi_d = 1'b0;
      got_d     = 1'b0;
      outcnt_d  = 3'd0;
      so_oe_d   = 1'b0;
    end else if (cs_rise) begin
      if (state == LS_WDATA && got && bitcnt == 3'd0 && !prot && !busy)
        start_arr = 1'b1;
      if (state == LS_CFGW && got && bitcnt == 3'd0 && !busy)
        start_cfg = 1'b1;
      state_d = LS_IDLE;
      so_oe_d = 1'b0;
    end else if (cs_active) begin
      if (sck_rise) begin
        sh_d     = byte_in[6:0];
        bitcnt_d = bitcnt + 3'd1;
        if (bitcnt == 3'd7) begin
          case (state)
            LS_CMD: begin
              state_d = LS_SKIP;
              if (byte_in[7:4] == 4'h0 && (!busy || byte_in[2:0] == CMD_STAT_RD)) begin
                case (byte_in[2:0])
                  CMD_UNLOCK:  wel_d = 1'b1;
                  CMD_LOCK:    wel_d = 1'b0;
                  CMD_STAT_RD: state_d = LS_STAT;
                  CMD_STAT_WR: if (wel && !(cfg_wpen && !wp_n_s)) state_d = LS_CFGW;
                  CMD_ARR_RD: begin
                    is_wr_d = 1'b0;
                    state_d = LS_ADDR;
                  end
                  CMD_ARR_WR: if (wel) begin
                    is_wr_d = 1'b1;
                    pb_clr  = 1'b1;
                    state_d = LS_ADDR;
                  end
                  default: state_d = LS_SKIP;
                endcase
              end
            end
            LS_ADDR: begin
              addr_d    = {addr[7:0], byte_in};
              addr_hi_d = 1'b1;
              if (addr_hi) begin
                state_d  = is_wr ? LS_WDATA : LS_RDATA;
                prot_d   = guarded(cfg_bp, addr_d[ADDR_W-1 -: 2]);
                outcnt_d = 3'd0;
              end
            end
            LS_WDATA: begin
              pb_we                 = 1'b1;
              addr_d[PAGE_W-1:0]    = addr[PAGE_W-1:0] + 1'b1;
              got_d                 = 1'b1;
            end
            LS_CFGW: begin
              if (!got) cfg_buf_d = {byte_in[7], byte_in[3:2]};
              got_d = 1'b1;
            end
            default: ;
          endcase
        end
      end else if (sck_fall && (state == LS_RDATA || state == LS_STAT)) begin
        if (outcnt == 3'd0) begin
          load     = (state == LS_STAT) ? stat_word : rd_data;
          so_q_d   = load[7];
          tx_d     = {load[6:0], 1'b0};
          outcnt_d = 3'd7;
          so_oe_d  = 1'b1;
          if (state == LS_RDATA) addr_d = addr + 16'd1;
        end else begin
          so_q_d   = tx[7];
          tx_d     = {tx[6:0], 1'b0};
          outcnt_d = outcnt - 3'd1;
        end
      end
    end

    if (wr_done) wel_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= LS_IDLE;
      cs_prev  <= 1'b1;
      sck_prev <= 1'b0;
      bitcnt   <= 3'd0;
      sh       <= 7'd0;
      addr     <= 16'd0;
      addr_hi  <= 1'b0;
      is_wr    <= 1'b0;
      wel      <= 1'b0;
      tx       <= 8'd0;
      outcnt   <= 3'd0;
      so_q     <= 1'b0;
      so_oe    <= 1'b0;
      got      <= 1'b0;
      prot     <= 1'b0;
      cfg_buf  <= 3'd0;
    end else begin
      state    <= state_d;
      cs_prev  <= cs_n_s;
      sck_prev <= sck_s;
      bitcnt   <= bitcnt_d;
      sh       <= sh_d;
      addr     <= addr_d;
      addr_hi  <= addr_hi_d;
      is_wr    <= is_wr_d;
      wel      <= wel_d;
      tx       <= tx_d;
      outcnt   <= outcnt_d;
      so_q     <= so_q_d;
      so_oe    <= so_oe_d;
      got      <= got_d;
      prot     <= prot_d;
      cfg_buf  <= cfg_buf_d;
    end
  end

  assign rd_addr  = addr[ADDR_W-1:0];
  assign pb_col   = addr[PAGE_W-1:0];
  assign pb_din   = byte_in;
  assign page_sel = addr[ADDR_W-1:PAGE_W];
  assign cfg_din  = cfg_buf;

  // R7: the end of an internal write leaves the latch clear
  p_wel_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wel);

  // R12: no drive on SO once the select is seen high
  p_so_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |-> !so_oe);

  // R4: an internal cycle is only launched while the latch is set
  p_start_needs_wel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_arr || start_cfg) |-> wel);

endmodule

// File: rtl/eeprom_store.sv
module eeprom_store #(
  parameter int ADDR_W    = 7,
  parameter int PAGE_W    = 5,
  parameter int WR_CYCLES = 400
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [7:0]               rd_data,
  input  logic                     pb_clr,
  input  logic                     pb_we,
  input  logic [PAGE_W-1:0]        pb_col,
  input  logic [7:0]               pb_din,
  input  logic [ADDR_W-PAGE_W-1:0] page_sel,
  input  logic                     start_arr,
  input  logic                     start_cfg,
  input  logic [2:0]               cfg_din,
  output logic                     busy,
  output logic                     wr_done,
  output logic                     cfg_wpen,
  output logic [1:0]               cfg_bp
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int PG_W   = ADDR_W - PAGE_W;
  localparam int CNT_W  = $clog2(WR_CYCLES + 1);

  logic [7:0]       mem  [DEPTH];
  logic [7:0]       pbuf [PAGE_N];
  logic [PAGE_N-1:0] pmask;

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt, cnt_d;
  logic             kind_cfg, kind_cfg_d;
  logic [PG_W-1:0]  tgt, tgt_d;
  logic [2:0]       cfg_hold, cfg_hold_d;
  logic             done;
  logic             commit_arr, commit_cfg;

  always_comb begin
    busy_d     = busy_q;
    cnt_d      = cnt;
    kind_cfg_d = kind_cfg;
    tgt_d      = tgt;
    cfg_hold_d = cfg_hold;
    done       = 1'b0;
    if (start_arr || start_cfg) begin
      busy_d     = 1'b1;
      cnt_d      = CNT_W'(WR_CYCLES - 1);
      kind_cfg_d = start_cfg;
      tgt_d      = page_sel;
      cfg_hold_d = cfg_din;
    end else if (busy_q) begin
      if (cnt == '0) begin
        busy_d = 1'b0;
        done   = 1'b1;
      end else begin
        cnt_d = cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      cnt      <= '0;
      kind_cfg <= 1'b0;
      tgt      <= '0;
      cfg_hold <= 3'd0;
    end else begin
      busy_q   <= busy_d;
      cnt      <= cnt_d;
      kind_cfg <= kind_cfg_d;
      tgt      <= tgt_d;
      cfg_hold <= cfg_hold_d;
    end
  end

  assign commit_arr = done && !kind_cfg;
  assign commit_cfg = done && kind_cfg;

  // page buffer: one byte and one valid flag per column
  for (genvar c = 0; c < PAGE_N; c++) begin : g_col
    localparam logic [PAGE_W-1:0] COL = PAGE_W'(c);
    logic col_hit;
    assign col_hit = pb_we && (pb_col == COL);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pbuf[c]  <= 8'h00;
        pmask[c] <= 1'b0;
      end else begin
        if (col_hit) pbuf[c] <= pb_din;
        if (pb_clr)       pmask[c] <= 1'b0;
        else if (col_hit) pmask[c] <= 1'b1;
      end
    end
  end

  // array words: copied from the buffer at the end of an internal write
  for (genvar a = 0; a < DEPTH; a++) begin : g_word
    localparam logic [ADDR_W-1:0] ADR = ADDR_W'(a);
    logic word_en;
    assign word_en = commit_arr && (ADR[ADDR_W-1:PAGE_W] == tgt) && pmask[a % PAGE_N];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mem[a] <= 8'h00;
      else if (word_en) mem[a] <= pbuf[a % PAGE_N];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_wpen <= 1'b0;
      cfg_bp   <= 2'b00;
    end else if (commit_cfg) begin
      cfg_wpen <= cfg_hold[2];
      cfg_bp   <= cfg_hold[1:0];
    end
  end

  assign rd_data = mem[rd_addr];
  assign busy    = busy_q;
  assign wr_done = done;

  // R7: a launch always raises busy on the next cycle
  p_start_sets_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_arr || start_cfg) |=> busy_q);

  // R8: no new cycle is launched on top of a running one
  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_arr || start_cfg) |-> !busy_q);

  // R9: protect settings move only at the end of a status write
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_cfg |=> $stable({cfg_wpen, cfg_bp}));

endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave #(
  parameter int ADDR_W    = 7,
  parameter int PAGE_W    = 5,
  parameter int WR_CYCLES = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic wp_n,
  output logic so
);

  localparam int PG_W = ADDR_W - PAGE_W;

  logic              rst_m, rst_s;
  logic [3:0]        pins_s;
  logic              busy, wr_done, cfg_wpen;
  logic [1:0]        cfg_bp;
  logic [7:0]        rd_data, pb_din;
  logic [ADDR_W-1:0] rd_addr;
  logic              pb_clr, pb_we, start_arr, start_cfg;
  logic [PAGE_W-1:0] pb_col;
  logic [PG_W-1:0]   page_sel;
  logic [2:0]        cfg_din;
  logic              so_q, so_oe;

  // reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  // bit order {wp_n, si, sck, cs_n}
  eeprom_pin_sync #(.W(4), .RST_VAL(4'b1001)) u_sync (
    .clk     (clk),
    .rst_n   (rst_s),
    .pin_in  ({wp_n, si, sck, cs_n}),
    .pin_lvl (pins_s)
  );

  eeprom_link #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_link (
    .clk       (clk),
    .rst_n     (rst_s),
    .cs_n_s    (pins_s[0]),
    .sck_s     (pins_s[1]),
    .si_s      (pins_s[2]),
    .wp_n_s    (pins_s[3]),
    .busy      (busy),
    .wr_done   (wr_done),
    .cfg_wpen  (cfg_wpen),
    .cfg_bp    (cfg_bp),
    .rd_data   (rd_data),
    .rd_addr   (rd_addr),
    .pb_clr    (pb_clr),
    .pb_we     (pb_we),
    .pb_col    (pb_col),
    .pb_din    (pb_din),
    .page_sel  (page_sel),
    .start_arr (start_arr),
    .start_cfg (start_cfg),
    .cfg_din   (cfg_din),
    .so_q      (so_q),
    .so_oe     (so_oe)
  );

  eeprom_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_store (
    .clk       (clk),
    .rst_n     (rst_s),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .pb_clr    (pb_clr),
    .pb_we     (pb_we),
    .pb_col    (pb_col),
    .pb_din    (pb_din),
    .page_sel  (page_sel),
    .start_arr (start_arr),
    .start_cfg (start_cfg),
    .cfg_din   (cfg_din),
    .busy      (busy),
    .wr_done   (wr_done),
    .cfg_wpen  (cfg_wpen),
    .cfg_bp    (cfg_bp)
  );

  assign so = so_oe ? so_q : 1'bz;

endmodule

// File: tb/tb_spi_eeprom_slave.sv
`timescale 1ns/1ps
module tb_spi_eeprom_slave;

  localparam int WRC = 1200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic si = 1'b0;
  logic wp_n = 1'b1;
  wire  so_w;
  pullup (so_w);

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  spi_eeprom_slave #(.ADDR_W(7), .PAGE_W(5), .WR_CYCLES(WRC)) dut (
    .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .sck (sck),
    .si (si), .wp_n (wp_n), .so (so_w)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic shift_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i >= 8 - nb; i--) begin
      si = tx[i];
      #40;
      rx[i] = so_w;
      sck = 1'b1;
      #40;
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    shift_bits(tx, 8, rx);
  endtask

  task automatic sel();
    cs_n = 1'b0;
    #40;
  endtask

  task automatic desel();
    #40;
    cs_n = 1'b1;
    #120;
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] d;
    sel(); xfer(op, d); desel();
  endtask

  task automatic stat_chk(input string tag, input logic [7:0] exp);
    logic [7:0] d;
    sel();
    xfer(8'h05, d);
    xfer(8'h00, d); check(tag, d, exp);
    xfer(8'h00, d); check(tag, d, exp);
    desel();
  endtask

  task automatic wr_arr(input logic [15:0] a, input int n, input logic [31:0] dat);
    logic [7:0] d;
    sel();
    xfer(8'h02, d); xfer(a[15:8], d); xfer(a[7:0], d);
    for (int k = 0; k < n; k++) xfer(dat[31-8*k -: 8], d);
    desel();
  endtask

  task automatic rd_chk(input string tag, input logic [15:0] a, input int n, input logic [31:0] exp);
    logic [7:0] d;
    sel();
    xfer(8'h03, d); xfer(a[15:8], d); xfer(a[7:0], d);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, d);
      check(tag, d, exp[31-8*k -: 8]);
    end
    desel();
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    logic [7:0] d;
    sel(); xfer(8'h01, d); xfer(v, d); desel();
  endtask

  task automatic wait_wr();
    repeat (WRC + 40) @(posedge clk);
  endtask

  task automatic t_reset();
    check("R1 so idle", {7'd0, so_w}, 8'h01);
    stat_chk("R1 status", 8'h00);
    rd_chk("R1 array", 16'h0000, 2, 32'h0000_0000);
    check("R12 so after frame", {7'd0, so_w}, 8'h01);
  endtask

  task automatic t_no_wel();
    wr_arr(16'h0010, 1, 32'hAA00_0000);
    stat_chk("R4 no busy", 8'h00);
    rd_chk("R4 array", 16'h0010, 1, 32'h0000_0000);
  endtask

  task automatic t_decode();
    cmd(8'h0E);
    stat_chk("R2 R3 set with bit3", 8'h02);
    cmd(8'h84);
    stat_chk("R2 upper nibble", 8'h02);
    wp_n = 1'b0;
    cmd(8'h0C);
    stat_chk("R3 clear with wp low", 8'h00);
    wp_n = 1'b1;
  endtask

  task automatic t_page_write();
    logic [7:0] d;
    cmd(8'h06);
    wr_arr(16'h001E, 4, 32'h1122_3344);
    stat_chk("R7 busy", 8'hFF);
    sel();
    xfer(8'h03, d); xfer(8'h00, d); xfer(8'h1E, d); xfer(8'h00, d);
    desel();
    check("R8 read ignored", d, 8'hFF);
    wait_wr();
    stat_chk("R7 done", 8'h00);
    rd_chk("R5 page tail", 16'h001E, 3, 32'h1122_0000);
    rd_chk("R5 page wrap", 16'h0000, 2, 32'h3344_0000);
  endtask

  task automatic t_abort();
    logic [7:0] d;
    cmd(8'h06);
    sel();
    xfer(8'h02, d); xfer(8'h00, d); xfer(8'h40, d); xfer(8'h55, d);
    shift_bits(8'hF0, 4, d);
    desel();
    stat_chk("R5 partial no cycle", 8'h02);
    rd_chk("R5 partial array", 16'h0040, 1, 32'h0000_0000);
    cmd(8'h04);
  endtask

  task automatic t_wrap();
    cmd(8'h06);
    wr_arr(16'h807F, 1, 32'h9A00_0000);
    wait_wr();
    rd_chk("R6 wrap end", 16'h007F, 2, 32'h9A33_0000);
    rd_chk("R6 high bits", 16'hFF7F, 1, 32'h9A00_0000);
  endtask

  task automatic t_cfg();
    wr_cfg(8'hFC);
    stat_chk("R4 cfg without wel", 8'h00);
    cmd(8'h06);
    wr_cfg(8'hFC);
    stat_chk("R7 cfg busy", 8'hFF);
    wait_wr();
    stat_chk("R9 cfg value", 8'h8C);
  endtask

  task automatic t_protect_all();
    cmd(8'h06);
    stat_chk("R10 wel set", 8'h8E);
    wr_arr(16'h0005, 1, 32'h7700_0000);
    stat_chk("R10 all dropped", 8'h8E);
    rd_chk("R10 all array", 16'h0005, 1, 32'h0000_0000);
  endtask

  task automatic t_wp_pin();
    wp_n = 1'b0;
    wr_cfg(8'h04);
    stat_chk("R11 wp low ignored", 8'h8E);
    wp_n = 1'b1;
    wr_cfg(8'h04);
    wait_wr();
    stat_chk("R11 wp high taken", 8'h04);
  endtask

  task automatic t_quarter();
    cmd(8'h06);
    wr_arr(16'h0060, 1, 32'h1200_0000);
    stat_chk("R10 quarter dropped", 8'h06);
    rd_chk("R10 quarter array", 16'h0060, 1, 32'h0000_0000);
    wr_arr(16'h005F, 1, 32'h3400_0000);
    wait_wr();
    rd_chk("R10 below quarter", 16'h005F, 1, 32'h3400_0000);
    stat_chk("R10 quarter status", 8'h04);
  endtask

  task automatic t_half();
    cmd(8'h06);
    wr_cfg(8'h08);
    wait_wr();
    stat_chk("R9 half cfg", 8'h08);
    cmd(8'h06);
    wr_arr(16'h0040, 1, 32'h5600_0000);
    stat_chk("R10 half dropped", 8'h0A);
    wr_arr(16'h003F, 1, 32'h7800_0000);
    wait_wr();
    rd_chk("R10 half edge", 16'h003F, 2, 32'h7800_0000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    repeat (10) @(posedge clk);
    t_reset();
    t_no_wel();
    t_decode();
    t_page_write();
    t_abort();
    t_wrap();
    t_cfg();
    t_protect_all();
    t_wp_pin();
    t_quarter();
    t_half();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule